// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address for a paging scheme built on 4 KB pages. It works as a hardware walker. It reads one entry from a top-level directory, then one entry from the second-level table that entry points to. From the second entry it forms the physical address. Each table holds 1K entries of 4 bytes.

A requester hands over a linear address and the directory base of the current context through a valid/ready request channel. It gets back one response carrying the physical address, or a fault flag that names the failing level. The walker reaches memory through a simple read port that allows only one read in flight. The read request uses a valid/ready handshake, and the data comes back as a one-cycle valid pulse. The walker takes one translation at a time.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The first memory read goes to `ctx_base + 4 * laddr[31:22]` (32-bit sum). `ctx_base` and `req_laddr` are captured in the accepting cycle, so later changes on those inputs have no effect on the walk.
- R3: The second read goes to `{dir_entry[31:12], 12'h000} + 4 * laddr[21:12]`. It is issued only after a directory entry with bit 0 set has been returned.
- R4: When both entries have bit 0 set, the response has `rsp_fault` = 0 and `rsp_paddr` = `{table_entry[31:12], laddr[11:0]}`, after exactly two memory reads.
- R5: When the directory entry has bit 0 clear, the response has `rsp_fault` = 1, `rsp_fault_lvl` = 0 and `rsp_paddr` = 0, and no second memory read is made.
- R6: When the table entry has bit 0 clear, the response has `rsp_fault` = 1, `rsp_fault_lvl` = 1 and `rsp_paddr` = 0.
- R7: One walk runs at a time. `req_ready` stays 0 from acceptance until the response handshake completes. At most one memory read is in flight. `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` accepts it.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and all response fields hold their values.
- R9: `rsp_laddr` returns the linear address of the request being answered, for faults and successes alike.
- R10: Bits 11:1 of both entries are ignored. They change neither the table read address nor the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_laddr | input | 32 | Linear address to translate |
| ctx_base | input | 32 | Byte address of the context's top directory |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | 1 when the walk hit a non-present entry |
| rsp_fault_lvl | output | 1 | Failing level: 0 directory, 1 table |
| rsp_laddr | output | 32 | Linear address of this result |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying read data |
| mem_rsp_data | input | 32 | Entry contents |

## Verification
Some properties are checked on every cycle. After a directory fault, the response appears in the next cycle with level 0 and no read is left pending. After a table fault, the response carries level 1. On success, the response keeps the page offset of the echoed linear address. A pending read holds its address, a stalled response holds its fields, and the request channel stays closed while a read or a response is outstanding. Other behaviour only the bench scenarios can show, because it depends on the memory contents. That covers the exact directory and table read addresses, the full physical address, the number of reads per walk, and the capture of base and address at acceptance. It also covers the masking of the spare entry bits. Random memory stalls and random response back-pressure are used throughout.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int LA_W       = 32;
  localparam int DIR_W      = 10;
  localparam int TBL_W      = 10;
  localparam int OFF_W      = 12;
  localparam int ENTRY_W    = 32;
  localparam int ENTRY_B    = 4;
  localparam int IDX_SHIFT  = $clog2(ENTRY_B);
  localparam int FRAME_W    = LA_W - OFF_W;
  localparam int PRESENT_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_FETCH_DIR = 3'd1,
    ST_WAIT_DIR  = 3'd2,
    ST_FETCH_PTE = 3'd3,
    ST_WAIT_PTE  = 3'd4,
    ST_DONE      = 3'd5
  } walk_state_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } fault_lvl_e;

  typedef struct packed {
    logic [DIR_W-1:0] dir;
    logic [TBL_W-1:0] tbl;
    logic [OFF_W-1:0] off;
  } laddr_t;

  function automatic logic entry_present(input logic [ENTRY_W-1:0] e);
    return e[PRESENT_BIT];
  endfunction

  function automatic logic [FRAME_W-1:0] entry_frame(input logic [ENTRY_W-1:0] e);
    return e[ENTRY_W-1 -: FRAME_W];
  endfunction

  function automatic logic [LA_W-1:0] scaled_dir(input laddr_t la);
    return {{(LA_W-DIR_W-IDX_SHIFT){1'b0}}, la.dir, {IDX_SHIFT{1'b0}}};
  endfunction

  function automatic logic [LA_W-1:0] scaled_tbl(input laddr_t la);
    return {{(LA_W-TBL_W-IDX_SHIFT){1'b0}}, la.tbl, {IDX_SHIFT{1'b0}}};
  endfunction

  function automatic logic [LA_W-1:0] dir_slot_addr(input logic [LA_W-1:0] base,
                                                    input laddr_t la);
    return base + scaled_dir(la);
  endfunction

  function automatic logic [LA_W-1:0] tbl_slot_addr(input logic [FRAME_W-1:0] frame,
                                                    input laddr_t la);
    return {frame, {OFF_W{1'b0}}} + scaled_tbl(la);
  endfunction

  function automatic logic [LA_W-1:0] join_phys(input logic [FRAME_W-1:0] frame,
                                                input laddr_t la);
    return {frame, la.off};
  endfunction

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        rsp_ready,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        entry_ok,
  output walk_state_e state,
  output logic        req_ready,
  output logic        mem_req_valid,
  output logic        rsp_valid,
  output logic        pte_phase,
  output logic        accept_evt,
  output logic        dir_rsp_evt,
  output logic        dir_fault_evt,
  output logic        pte_rsp_evt,
  output logic        pte_fault_evt,
  output logic        pte_ok_evt
);

  walk_state_e state_q, state_d;

  assign state = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_valid)     state_d = ST_FETCH_DIR;
      ST_FETCH_DIR: if (mem_req_ready) state_d = ST_WAIT_DIR;
      ST_WAIT_DIR:  if (mem_rsp_valid) state_d = entry_ok ? ST_FETCH_PTE : ST_DONE;
      ST_FETCH_PTE: if (mem_req_ready) state_d = ST_WAIT_PTE;
      ST_WAIT_PTE:  if (mem_rsp_valid) state_d = ST_DONE;
      ST_DONE:      if (rsp_ready)     state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_FETCH_DIR) || (state_q == ST_FETCH_PTE);
  assign rsp_valid     = (state_q == ST_DONE);
  assign pte_phase     = (state_q == ST_FETCH_PTE);

  assign accept_evt    = req_ready && req_valid;
  assign dir_rsp_evt   = (state_q == ST_WAIT_DIR) && mem_rsp_valid;
  assign dir_fault_evt = dir_rsp_evt && !entry_ok;
  assign pte_rsp_evt   = (state_q == ST_WAIT_PTE) && mem_rsp_valid;
  assign pte_fault_evt = pte_rsp_evt && !entry_ok;
  assign pte_ok_evt    = pte_rsp_evt && entry_ok;

endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LA_W-1:0]    req_laddr,
  input  logic [LA_W-1:0]    ctx_base,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  input  logic               pte_phase,
  input  logic               accept_evt,
  input  logic               dir_rsp_evt,
  input  logic               dir_fault_evt,
  input  logic               pte_rsp_evt,
  input  logic               pte_ok_evt,
  output logic               entry_ok,
  output logic [LA_W-1:0]    mem_req_addr,
  output logic [LA_W-1:0]    rsp_paddr,
  output logic               rsp_fault,
  output logic               rsp_fault_lvl,
  output logic [LA_W-1:0]    rsp_laddr
);

  laddr_t             la_q;
  logic [LA_W-1:0]    base_q;
  logic [FRAME_W-1:0] dir_frame_q;
  logic [FRAME_W-1:0] rsp_frame;
  logic               unused_entry_bits;

  assign entry_ok          = entry_present(mem_rsp_data);
  assign rsp_frame         = entry_frame(mem_rsp_data);
  assign unused_entry_bits = ^mem_rsp_data[OFF_W-1:PRESENT_BIT+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      la_q   <= '0;
      base_q <= '0;
    end else if (accept_evt) begin
      la_q   <= laddr_t'(req_laddr);
      base_q <= ctx_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           dir_frame_q <= '0;
    else if (dir_rsp_evt) dir_frame_q <= rsp_frame;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_paddr     <= '0;
      rsp_fault     <= 1'b0;
      rsp_fault_lvl <= LVL_DIR;
    end else if (dir_fault_evt) begin
      rsp_paddr     <= '0;
      rsp_fault     <= 1'b1;
      rsp_fault_lvl <= LVL_DIR;
    end else if (pte_rsp_evt) begin
      rsp_paddr     <= pte_ok_evt ? join_phys(rsp_frame, la_q) : '0;
      rsp_fault     <= !pte_ok_evt;
      rsp_fault_lvl <= LVL_TBL;
    end
  end

  assign mem_req_addr = pte_phase ? tbl_slot_addr(dir_frame_q, la_q)
                                  : dir_slot_addr(base_q, la_q);
  assign rsp_laddr    = la_q;

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_laddr,
  input  logic [31:0] ctx_base,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        rsp_fault_lvl,
  output logic [31:0] rsp_laddr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);

  walk_state_e walk_state;
  logic        pte_phase;
  logic        entry_ok;
  logic        accept_evt;
  logic        dir_rsp_evt;
  logic        dir_fault_evt;
  logic        pte_rsp_evt;
  logic        pte_fault_evt;
  logic        pte_ok_evt;
  logic        unused_state;

  assign unused_state = ^walk_state;

  pgwalk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rsp_ready     (rsp_ready),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .entry_ok      (entry_ok),
    .state         (walk_state),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .rsp_valid     (rsp_valid),
    .pte_phase     (pte_phase),
    .accept_evt    (accept_evt),
    .dir_rsp_evt   (dir_rsp_evt),
    .dir_fault_evt (dir_fault_evt),
    .pte_rsp_evt   (pte_rsp_evt),
    .pte_fault_evt (pte_fault_evt),
    .pte_ok_evt    (pte_ok_evt)
  );

  pgwalk_dpath u_dpath (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_laddr     (req_laddr),
    .ctx_base      (ctx_base),
    .mem_rsp_data  (mem_rsp_data),
    .pte_phase     (pte_phase),
    .accept_evt    (accept_evt),
    .dir_rsp_evt   (dir_rsp_evt),
    .dir_fault_evt (dir_fault_evt),
    .pte_rsp_evt   (pte_rsp_evt),
    .pte_ok_evt    (pte_ok_evt),
    .entry_ok      (entry_ok),
    .mem_req_addr  (mem_req_addr),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .rsp_laddr     (rsp_laddr)
  );

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic        rsp_fault,
  input logic        rsp_fault_lvl,
  input logic [31:0] rsp_laddr,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        dir_fault_evt,
  input logic        pte_fault_evt,
  input logic        pte_ok_evt
);

  a_r5_dir_fault_reply: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fault_evt |=> (rsp_valid && rsp_fault && !rsp_fault_lvl &&
                       rsp_paddr == 32'h0 && !mem_req_valid));

  a_r6_tbl_fault_reply: assert property (@(posedge clk) disable iff (!rst_n)
    pte_fault_evt |=> (rsp_valid && rsp_fault && rsp_fault_lvl && rsp_paddr == 32'h0));

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pte_ok_evt |=> (rsp_valid && !rsp_fault && rsp_paddr[11:0] == rsp_laddr[11:0]));

  a_r7_closed_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  a_r7_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r8_reply_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) &&
                                   $stable(rsp_fault_lvl) && $stable(rsp_laddr)));

  a_r7_one_role: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && mem_req_valid));

endmodule

bind pgwalk_top pgwalk_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_fault     (rsp_fault),
  .rsp_fault_lvl (rsp_fault_lvl),
  .rsp_laddr     (rsp_laddr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .dir_fault_evt (dir_fault_evt),
  .pte_fault_evt (pte_fault_evt),
  .pte_ok_evt    (pte_ok_evt)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_laddr, ctx_base;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_paddr, rsp_laddr;
  logic        rsp_fault, rsp_fault_lvl;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] seen_addr [4];
  int          seen_n;
  bit          mem_pend;
  int          mem_dly;
  logic [31:0] mem_pend_addr;

  always #5 clk = ~clk;

  pgwalk_top u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_laddr     (req_laddr),
    .ctx_base      (ctx_base),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .rsp_laddr     (rsp_laddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  function automatic logic [31:0] first_slot(input logic [31:0] base, input logic [31:0] la);
    return base + (32'(la >> 22) * 32'd4);
  endfunction

  function automatic logic [31:0] second_slot(input logic [31:0] de, input logic [31:0] la);
    return (de & 32'hFFFF_F000) + (((la >> 12) & 32'h3FF) * 32'd4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] base, input logic [31:0] la,
                      input logic [31:0] de, input logic [31:0] te);
    mem_img.delete();
    mem_img[first_slot(base, la)] = de;
    mem_img[second_slot(de, la)] = te;
  endtask

  // memory responder: one read in flight, random accept and latency
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    mem_pend      = 1'b0;
    mem_dly       = 0;
    mem_pend_addr = 32'h0;
    seen_n        = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_pend) begin
        mem_req_ready = 1'b0;
        if (mem_dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(mem_pend_addr);
          mem_pend      = 1'b0;
        end else mem_dly--;
      end else begin
        mem_req_ready = ($urandom % 4) != 0;
        if (mem_req_valid && mem_req_ready) begin
          if (seen_n < 4) seen_addr[seen_n] = mem_req_addr;
          seen_n++;
          mem_pend_addr = mem_req_addr;
          mem_pend      = 1'b1;
          mem_dly       = $urandom % 3;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] base, input logic [31:0] la, input string tag);
    logic [31:0] da, de, ta, te, exp_pa, pa0;
    logic        exp_f, exp_l;
    int          exp_n, t, h;
    da = first_slot(base, la);
    de = rd(da);
    ta = second_slot(de, la);
    te = rd(ta);
    if (!de[0]) begin
      exp_f = 1'b1; exp_l = 1'b0; exp_n = 1; exp_pa = 32'h0;
    end else if (!te[0]) begin
      exp_f = 1'b1; exp_l = 1'b1; exp_n = 2; exp_pa = 32'h0;
    end else begin
      exp_f = 1'b0; exp_l = 1'b1; exp_n = 2; exp_pa = {te[31:12], la[11:0]};
    end
    seen_n = 0;
    @(negedge clk);
    chk({tag, " R7 idle ready"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_laddr = la;
    ctx_base  = base;
    @(negedge clk);
    req_valid = 1'b0;
    req_laddr = $urandom;
    ctx_base  = $urandom;
    chk({tag, " R7 closed while walking"}, 32'(req_ready), 32'd0);
    t = 0;
    while (!rsp_valid && t < 300) begin
      @(negedge clk);
      t++;
    end
    if (!rsp_valid) begin
      chk({tag, " R7 response arrives"}, 32'd0, 32'd1);
      return;
    end
    chk({tag, " R2 first read address"}, seen_addr[0], da);
    if (exp_n == 2) chk({tag, " R3 second read address"}, seen_addr[1], ta);
    if (exp_f && !exp_l) chk({tag, " R5 read count"}, 32'(seen_n), 32'd1);
    else                 chk({tag, " R4 read count"}, 32'(seen_n), 32'd2);
    chk({tag, " R4 R5 R6 fault flag"}, 32'(rsp_fault), 32'(exp_f));
    if (exp_f) chk({tag, " R5 R6 fault level"}, 32'(rsp_fault_lvl), 32'(exp_l));
    chk({tag, " R4 physical address"}, rsp_paddr, exp_pa);
    chk({tag, " R9 echoed address"}, rsp_laddr, la);
    h = $urandom % 4;
    pa0 = rsp_paddr;
    repeat (h) @(negedge clk);
    chk({tag, " R8 held valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " R8 held address"}, rsp_paddr, pa0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({tag, " R7 response retired"}, 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] b, la, de, te;
    void'($urandom(32'h1234_5eed));
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_laddr = 32'h0;
    ctx_base  = 32'h0;
    rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset req_ready", 32'(req_ready), 32'd1);
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 reset mem_req_valid", 32'(mem_req_valid), 32'd0);

    // directed: good walk
    b = 32'h0001_0000; la = 32'h0040_3ABC;
    fill(b, la, 32'h0002_0001, 32'h0ABC_D001);
    walk(b, la, "dir-good");
    // directory not present
    fill(b, la, 32'h0002_0000, 32'h0ABC_D001);
    walk(b, la, "R5 dir-missing");
    // table not present
    fill(b, la, 32'h0002_0001, 32'h0ABC_D000);
    walk(b, la, "R6 tbl-missing");
    // top indices and offset
    b = 32'hFFFF_F000; la = 32'hFFFF_FFFF;
    fill(b, la, 32'h1234_5001, 32'h89AB_C001);
    walk(b, la, "R2 top-index");
    // all-zero address
    b = 32'h0000_0000; la = 32'h0000_0000;
    fill(b, la, 32'h0000_1001, 32'h0000_2001);
    walk(b, la, "R3 zero-address");
    // spare entry bits set
    b = 32'h0030_0000; la = 32'h1357_9BDF;
    fill(b, la, 32'h0055_5FFF, 32'h00AA_AFFF);
    walk(b, la, "R10 spare-bits");

    for (int i = 0; i < 80; i++) begin
      b  = $urandom & 32'hFFFF_FFFC;
      la = $urandom;
      de = $urandom;
      de[0] = ($urandom % 8) != 0;
      te = $urandom;
      te[0] = ($urandom % 8) != 0;
      fill(b, la, de, te);
      walk(b, la, "rand");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule